// File: doc/BRIEF.md
# Compare-and-Branch Resolver

This block settles the outcome of a compare-and-jump instruction. It receives the 32-bit instruction word, the two source operand values already read from the register file, the address of the current instruction and a precomputed jump target. It decodes the instruction, forms the second operand and evaluates the 4-bit condition field. It then reports whether the branch is taken, which address comes next, and whether the condition code is one it does not recognise.

Two encodings share one condition field. In the register-register form, the second operand comes from the second source register. In the register-immediate form, it is a 16-bit constant taken from the instruction and sign-extended. Condition codes split into an equality and unsigned group at the low end (0 to 4) and a signed group (hex C and D). Every other code is reported as illegal and never branches.

The unit is purely combinational by default. Setting the parameter `REGISTERED` to 1 adds one flop stage on all three outputs, for use where the result must meet a pipeline boundary.

Top module: `branch_resolve`

## Requirements
- R1: The opcode is `instr[31:24]` and the condition code is `instr[23:20]`. Opcode 8'h40 (parameter `OPC_REG`) selects the register form, and opcode 8'h41 (parameter `OPC_IMM`) selects the immediate form.
- R2: In the register form, the second operand is `rs2_val`, and bits `instr[15:0]` have no effect on any output.
- R3: In the immediate form, the second operand is `instr[15:0]` sign-extended to 32 bits, and `rs2_val` has no effect on any output.
- R4: Condition 0 is always taken. Condition 1 is taken when the two operands differ. Condition 2 is taken when they are equal.
- R5: Condition 3 is taken when `rs1_val` is greater than the second operand as unsigned numbers. Condition 4 is taken when it is greater or equal as unsigned numbers.
- R6: Condition 4'hC is taken when `rs1_val` is greater than the second operand in two's complement. Condition 4'hD is taken when it is greater or equal in two's complement.
- R7: When the branch is taken, `next_ip` equals `jump_target`.
- R8: When the branch is not taken, `next_ip` equals `cur_ip + IP_STEP` (default 4), wrapping modulo 2^32.
- R9: On a branch opcode, condition codes 5 to 4'hB, 4'hE and 4'hF drive `bad_cond` to 1 and `taken` to 0.
- R10: Any opcode other than the two branch opcodes gives `taken` = 0 and `bad_cond` = 0, with `next_ip` following R8.
- R11: With `REGISTERED` = 1, all outputs appear one clock after their inputs. While `rst_n` is low, all outputs are held at zero. With `REGISTERED` = 0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage and for assertion sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Instruction word under evaluation |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand (register form only) |
| cur_ip | input | 32 | Address of the current instruction |
| jump_target | input | 32 | Address loaded when the branch is taken |
| taken | output | 1 | Branch decision |
| next_ip | output | 32 | Address of the next instruction |
| bad_cond | output | 1 | Unrecognised condition code on a branch opcode |

## Verification
The assertions sample the combinational decision at each rising clock edge. They assume that the instruction word, operands, current address and target are stable around that edge. They also assume that the checks only mean something once reset has been released. The stimulus changes every input on the falling edge and keeps it constant for a full cycle. It holds reset for several cycles before the first vector is applied. Operands are drawn from the sign and magnitude corners (0, 1, the largest positive value, the most negative value, all ones and a small value). Every condition code is applied in both forms, so the signed and unsigned orderings of these operands disagree in many vectors.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 16;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'h0,
        CND_NE     = 4'h1,
        CND_EQ     = 4'h2,
        CND_GTU    = 4'h3,
        CND_GEU    = 4'h4,
        CND_GTS    = 4'hC,
        CND_GES    = 4'hD
    } cond_e;

    typedef struct packed {
        logic       is_branch;
        logic       imm_form;
        logic [3:0] cond;
    } br_dec_t;

endpackage

// File: rtl/br_field_decode.sv
module br_field_decode
    import branch_resolve_pkg::*;
#(
    parameter int         DATA_W  = 32,
    parameter logic [7:0] OPC_REG = 8'h40,
    parameter logic [7:0] OPC_IMM = 8'h41
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rs2_val,
    output br_dec_t            dec,
    output logic [DATA_W-1:0]  opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [7:0]       opcode;
    logic [IMM_W-1:0] imm;

    // R1: opcode in the top byte, condition in the nibble below it
    assign opcode = instr[31:24];
    assign imm    = instr[IMM_W-1:0];

    always_comb begin
        dec.is_branch = (opcode == OPC_REG) || (opcode == OPC_IMM);
        dec.imm_form  = (opcode == OPC_IMM);
        dec.cond      = instr[23:20];
        // R3: immediate is sign-extended; R2: register form uses rs2_val
        if (dec.imm_form)
            opnd_b = {{EXT_W{imm[IMM_W-1]}}, imm};
        else
            opnd_b = rs2_val;
    end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import branch_resolve_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  br_dec_t           dec,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              hit,
    output logic              bad
);
    logic eq, gtu, gts;
    logic legal, cond_true;

    assign eq  = (opnd_a == opnd_b);
    assign gtu = (opnd_a > opnd_b);
    assign gts = ($signed(opnd_a) > $signed(opnd_b));

    always_comb begin
        legal     = 1'b1;
        cond_true = 1'b0;
        unique case (dec.cond)
            CND_ALWAYS: cond_true = 1'b1;          // R4
            CND_NE:     cond_true = !eq;           // R4
            CND_EQ:     cond_true = eq;            // R4
            CND_GTU:    cond_true = gtu;           // R5
            CND_GEU:    cond_true = gtu || eq;     // R5
            CND_GTS:    cond_true = gts;           // R6
            CND_GES:    cond_true = gts || eq;     // R6
            default: begin                         // R9
                legal     = 1'b0;
                cond_true = 1'b0;
            end
        endcase
        hit = dec.is_branch && legal && cond_true;
        bad = dec.is_branch && !legal;             // R10 when not a branch
    end
endmodule

// File: rtl/br_ip_select.sv
module br_ip_select #(
    parameter int IP_W    = 32,
    parameter int IP_STEP = 4
) (
    input  logic            taken,
    input  logic [IP_W-1:0] cur_ip,
    input  logic [IP_W-1:0] jump_target,
    output logic [IP_W-1:0] next_ip
);
    localparam logic [IP_W-1:0] STEP = IP_W'(IP_STEP);

    logic [IP_W-1:0] fall_ip;

    assign fall_ip = cur_ip + STEP;                 // R8, wraps
    assign next_ip = taken ? jump_target : fall_ip; // R7
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int         DATA_W     = 32,
    parameter int         IP_W       = 32,
    parameter int         IP_STEP    = 4,
    parameter bit         REGISTERED = 1'b0,
    parameter logic [7:0] OPC_REG    = 8'h40,
    parameter logic [7:0] OPC_IMM    = 8'h41
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rs1_val,
    input  logic [DATA_W-1:0]  rs2_val,
    input  logic [IP_W-1:0]    cur_ip,
    input  logic [IP_W-1:0]    jump_target,
    output logic               taken,
    output logic [IP_W-1:0]    next_ip,
    output logic               bad_cond
);
    localparam logic [IP_W-1:0] STEP = IP_W'(IP_STEP);

    br_dec_t           dec;
    logic [DATA_W-1:0] opnd_b;
    logic              c_taken, c_bad;
    logic [IP_W-1:0]   c_next;
    logic              unused_fields;

    // register index fields are consumed by the register file, not here
    assign unused_fields = ^instr[19:IMM_W-4];

    br_field_decode #(
        .DATA_W (DATA_W),
        .OPC_REG(OPC_REG),
        .OPC_IMM(OPC_IMM)
    ) i_decode (
        .instr  (instr),
        .rs2_val(rs2_val),
        .dec    (dec),
        .opnd_b (opnd_b)
    );

    br_cond_eval #(.DATA_W(DATA_W)) i_eval (
        .dec   (dec),
        .opnd_a(rs1_val),
        .opnd_b(opnd_b),
        .hit   (c_taken),
        .bad   (c_bad)
    );

    br_ip_select #(.IP_W(IP_W), .IP_STEP(IP_STEP)) i_ipsel (
        .taken      (c_taken),
        .cur_ip     (cur_ip),
        .jump_target(jump_target),
        .next_ip    (c_next)
    );

    generate
        if (REGISTERED) begin : g_reg
            // R11: one flop stage, cleared by reset
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    taken    <= 1'b0;
                    next_ip  <= '0;
                    bad_cond <= 1'b0;
                end else begin
                    taken    <= c_taken;
                    next_ip  <= c_next;
                    bad_cond <= c_bad;
                end
            end
        end else begin : g_comb
            assign taken    = c_taken;
            assign next_ip  = c_next;
            assign bad_cond = c_bad;
        end
    endgenerate

    a_r7_taken_loads_target: assert property (@(posedge clk) disable iff (!rst_n)
        c_taken |-> (c_next == jump_target));

    a_r8_fallthrough_step: assert property (@(posedge clk) disable iff (!rst_n)
        !c_taken |-> (c_next == cur_ip + STEP));

    a_r9_bad_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad |-> !c_taken);

    a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:24] == OPC_REG || instr[31:24] == OPC_IMM) && instr[23:20] == 4'h0)
        |-> c_taken);

    a_r10_non_branch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:24] != OPC_REG && instr[31:24] != OPC_IMM) |-> (!c_taken && !c_bad));

    a_r4_eq_ne_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:24] == OPC_REG && (instr[23:20] == 4'h1 || instr[23:20] == 4'h2))
        |-> (c_taken == ((instr[23:20] == 4'h2) == (rs1_val == rs2_val))));
endmodule

// File: tb/test_branch_resolve.sv
`timescale 1ns/1ps
module test_branch_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0, cur_ip = '0, jump_target = '0;
    logic        taken, bad_cond, q_taken, q_bad;
    logic [31:0] next_ip, q_next;
    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    branch_resolve i_branch_resolve (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .cur_ip(cur_ip), .jump_target(jump_target),
        .taken(taken), .next_ip(next_ip), .bad_cond(bad_cond));

    branch_resolve #(.REGISTERED(1'b1)) i_branch_resolve_q (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .cur_ip(cur_ip), .jump_target(jump_target),
        .taken(q_taken), .next_ip(q_next), .bad_cond(q_bad));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic model_hit(logic [3:0] c, logic [31:0] a, logic [31:0] b);
        case (c)
            4'h0: return 1'b1;
            4'h1: return a != b;
            4'h2: return a == b;
            4'h3: return a > b;
            4'h4: return a >= b;
            4'hC: return $signed(a) > $signed(b);
            4'hD: return $signed(a) >= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_tag(logic [3:0] c);
        if (c <= 4'h2) return "R4";
        if (c <= 4'h4) return "R5";
        if (c == 4'hC || c == 4'hD) return "R6";
        return "R9";
    endfunction

    // apply one vector, check the combinational copy, then the registered copy (R11)
    task automatic run_vec(logic [31:0] ins, logic [31:0] a, logic [31:0] r2,
                           logic [31:0] ip, logic [31:0] tgt,
                           logic exp_t, logic exp_b, string tag);
        logic [31:0] exp_ip;
        exp_ip = exp_t ? tgt : ip + 32'd4;
        @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = r2; cur_ip = ip; jump_target = tgt;
        #1;
        chk({tag, " taken"}, {31'd0, taken}, {31'd0, exp_t});
        chk({tag, " bad_cond"}, {31'd0, bad_cond}, {31'd0, exp_b});
        chk({tag, exp_t ? " R7 next_ip" : " R8 next_ip"}, next_ip, exp_ip);
        @(posedge clk);
        #1;
        chk({tag, " R11 q_taken"}, {31'd0, q_taken}, {31'd0, exp_t});
        chk({tag, " R11 q_bad"}, {31'd0, q_bad}, {31'd0, exp_b});
        chk({tag, " R11 q_next"}, q_next, exp_ip);
    endtask

    initial begin
        logic [31:0] avals [6];
        logic [15:0] ivals [6];
        avals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h5};
        ivals = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5};

        repeat (3) @(posedge clk);
        #1;
        // R11: registered outputs are zero while reset is held
        chk("R11 reset q_taken", {31'd0, q_taken}, 32'd0);
        chk("R11 reset q_next", q_next, 32'd0);
        chk("R11 reset q_bad", {31'd0, q_bad}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [31:0] ip, tgt, b_ext, ins;
                    logic        legal;
                    legal = (c <= 4) || (c == 12) || (c == 13);
                    ip  = (c == 15) ? 32'hFFFF_FFFC : 32'h0000_1000 + 32'(c * 64 + i * 8 + j * 4);
                    tgt = 32'h8000_0000 | 32'(c * 256 + i * 16 + j);
                    // R1, R2: register form, low 16 bits filled with noise
                    ins = {8'h40, 4'(c), 4'h3, 16'h5A5A};
                    run_vec(ins, avals[i], avals[j], ip, tgt,
                            legal && model_hit(4'(c), avals[i], avals[j]), !legal,
                            {cond_tag(4'(c)), " R2 reg"});
                    // R1, R3: immediate form, rs2_val set to the opposite of the immediate
                    b_ext = {{16{ivals[j][15]}}, ivals[j]};
                    ins = {8'h41, 4'(c), 4'h3, ivals[j]};
                    run_vec(ins, avals[i], ~b_ext, ip, tgt,
                            legal && model_hit(4'(c), avals[i], b_ext), !legal,
                            {cond_tag(4'(c)), " R3 imm"});
                end
            end
        end

        // R10: opcodes other than the branch pair never branch or flag
        for (int k = 0; k < 4; k++) begin
            logic [7:0] op;
            op = (k == 0) ? 8'h00 : (k == 1) ? 8'h3F : (k == 2) ? 8'h42 : 8'hFF;
            run_vec({op, 4'h0, 4'h1, 16'h0000}, 32'h1, 32'h1, 32'h0000_2000 + 32'(k * 4),
                    32'h9000_0000, 1'b0, 1'b0, "R10 non-branch");
            run_vec({op, 4'h7, 4'h1, 16'h0000}, 32'h1, 32'h1, 32'hFFFF_FFFC,
                    32'h9000_0000, 1'b0, 1'b0, "R10 non-branch bad code");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule